// File: doc/BRIEF.md
# CPU-Bus Video Memory Bridge

This block places an 8K x 8 video memory into the address space of an 8-bit processor. The processor writes into the memory on its own slow clock. A separate, faster read clock drives the memory's read port. The bus strobes are active low. The block turns them into active-high enables for a simple dual-port memory that has independent write and read clocks.

An access selects the memory only when its address falls in the half-open window from 0x2000 up to, but not including, 0x4000. The memory word is the bus address minus the window base, cut to 13 bits. Processor read data is a registered choice among three sources: the memory's read port, a boot ROM data input for addresses below the window, and an all-ones idle value for everything else. The raw output of the fast read port is also available on its own port.

Top module: `cpu_vram_bridge`

## Requirements
- R1: A bus write with `cpu_mreq_n`=0 and `cpu_wr_n`=0 and an address in [0x2000, 0x4000) stores `cpu_wdata` into the memory on the rising edge of `cpu_clk`.
- R2: A write at address 0x1FFF or 0x4000 leaves every memory word unchanged. In particular, words 8191 and 0, which those addresses alias after truncation, keep their contents.
- R3: The memory word index is (`cpu_addr` - 0x2000) modulo 8192. Bus address 0x2000 reaches word 0 and bus address 0x3FFF reaches word 8191.
- R4: A write strobe with `cpu_mreq_n`=1 has no effect on the memory.
- R5: `vid_rdata` takes the addressed word on the first `vid_clk` rising edge at which a bus read (`cpu_mreq_n`=0, `cpu_rd_n`=0) is active with an address in the window. At any other edge it holds its value.
- R6: One `vid_clk` edge after an in-window bus read is presented, `cpu_rdata` equals the stored memory word.
- R7: One `vid_clk` edge after a bus read below 0x2000 is presented, `cpu_rdata` equals the `rom_data` value sampled at that edge.
- R8: `cpu_rdata` is 0xFF one `vid_clk` edge after a bus read at 0x4000 or above is presented, and also after any cycle in which no bus read is active.
- R9: While `vid_rst` is high, `cpu_rdata` becomes 0xFF and `vid_rdata` becomes 0x00. While `cpu_rst` is high, no write reaches the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Processor clock; memory write clock |
| cpu_rst | input | 1 | Synchronous active-high reset, write domain |
| vid_clk | input | 1 | Fast read clock |
| vid_rst | input | 1 | Synchronous active-high reset, read domain |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| rom_data | input | 8 | Boot ROM data for addresses below the window |
| cpu_rdata | output | 8 | Registered read data returned to the processor |
| vid_rdata | output | 8 | Registered output of the memory read port |

## Verification
If the decoder computes a wrong offset, the fault shows up only when the word is read back. Each read therefore compares against an address-dependent pattern, so a shifted or aliased word fails on its first readback. A window boundary that is off by one corrupts word 0 or word 8191. The test reads those words back immediately after the stray writes. A stale or wrong read-source select shows on `cpu_rdata` one `vid_clk` edge after the read is presented, and the checker flags that same edge.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/vram_decode.sv
module vram_decode
  import vram_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RAM_AW   = 13,
  parameter int WIN_BASE = 32'h2000
) (
  input  logic              wr_block,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              ram_we,
  output logic              ram_re,
  output logic [RAM_AW-1:0] ram_addr,
  output rd_src_e           rd_src
);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + (1 << RAM_AW));

  logic [ADDR_W:0] addr_x;
  logic in_win, below_win, mem_rd, mem_wr;

  always_comb begin
    addr_x    = {1'b0, addr};
    in_win    = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    below_win = addr_x < WIN_LO;
    mem_rd    = !mreq_n && !rd_n;
    mem_wr    = !mreq_n && !wr_n;
    ram_addr  = RAM_AW'(addr - ADDR_W'(WIN_BASE));
    ram_we    = mem_wr && in_win && !wr_block;
    ram_re    = mem_rd && in_win;
    if (mem_rd && in_win)         rd_src = SRC_RAM;
    else if (mem_rd && below_win) rd_src = SRC_ROM;
    else                          rd_src = SRC_IDLE;
  end
endmodule

// File: rtl/vram_sdp_ram.sv
module vram_sdp_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 13
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/vram_rd_mux.sv
module vram_rd_mux
  import vram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] rom_in,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] dout
);
  localparam logic [DATA_W-1:0] IDLE_VAL = '1;

  rd_src_e           src_r;
  logic [DATA_W-1:0] rom_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_r <= SRC_IDLE;
      rom_r <= '0;
    end else begin
      src_r <= src;
      rom_r <= rom_in;
    end
  end

  always_comb begin
    case (src_r)
      SRC_RAM: dout = ram_q;
      SRC_ROM: dout = rom_r;
      default: dout = IDLE_VAL;
    endcase
  end
endmodule

// File: rtl/cpu_vram_bridge.sv
module cpu_vram_bridge
  import vram_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RAM_AW   = 13,
  parameter int WIN_BASE = 32'h2000
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst,
  input  logic              vid_clk,
  input  logic              vid_rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_mreq_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [DATA_W-1:0] rom_data,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] vid_rdata
);
  logic              ram_we, ram_re;
  logic [RAM_AW-1:0] ram_addr;
  rd_src_e           rd_src;

  vram_decode #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .WIN_BASE(WIN_BASE)) u_dec (
    .wr_block (cpu_rst),
    .addr     (cpu_addr),
    .mreq_n   (cpu_mreq_n),
    .rd_n     (cpu_rd_n),
    .wr_n     (cpu_wr_n),
    .ram_we   (ram_we),
    .ram_re   (ram_re),
    .ram_addr (ram_addr),
    .rd_src   (rd_src)
  );

  vram_sdp_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .wr_clk  (cpu_clk),
    .wr_en   (ram_we),
    .wr_addr (ram_addr),
    .wr_data (cpu_wdata),
    .rd_clk  (vid_clk),
    .rd_rst  (vid_rst),
    .rd_en   (ram_re),
    .rd_addr (ram_addr),
    .rd_data (vid_rdata)
  );

  vram_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .clk    (vid_clk),
    .rst    (vid_rst),
    .src    (rd_src),
    .rom_in (rom_data),
    .ram_q  (vid_rdata),
    .dout   (cpu_rdata)
  );
endmodule

// File: rtl/vram_bridge_chk.sv
module vram_bridge_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RAM_AW   = 13,
  parameter int WIN_BASE = 32'h2000
) (
  input logic              vid_clk,
  input logic              vid_rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_mreq_n,
  input logic              cpu_rd_n,
  input logic [DATA_W-1:0] rom_data,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic [DATA_W-1:0] vid_rdata
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(WIN_BASE + (1 << RAM_AW));

  logic rd_act, in_w, low_w, high_w;
  assign rd_act = !cpu_mreq_n && !cpu_rd_n;
  assign in_w   = ({1'b0, cpu_addr} >= LO) && ({1'b0, cpu_addr} < HI);
  assign low_w  = {1'b0, cpu_addr} < LO;
  assign high_w = {1'b0, cpu_addr} >= HI;

  a_r5_hold_when_unread: assert property (@(posedge vid_clk) disable iff (vid_rst)
    !(rd_act && in_w) |=> $stable(vid_rdata));

  a_r6_ram_to_cpu: assert property (@(posedge vid_clk) disable iff (vid_rst)
    (rd_act && in_w) |=> (cpu_rdata == vid_rdata));

  a_r7_rom_to_cpu: assert property (@(posedge vid_clk) disable iff (vid_rst)
    (rd_act && low_w) |=> (cpu_rdata == $past(rom_data)));

  a_r8_high_is_ones: assert property (@(posedge vid_clk) disable iff (vid_rst)
    (rd_act && high_w) |=> (cpu_rdata == '1));

  a_r8_idle_is_ones: assert property (@(posedge vid_clk) disable iff (vid_rst)
    !rd_act |=> (cpu_rdata == '1));
endmodule

bind cpu_vram_bridge vram_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .WIN_BASE(WIN_BASE)
) u_chk (
  .vid_clk    (vid_clk),
  .vid_rst    (vid_rst),
  .cpu_addr   (cpu_addr),
  .cpu_mreq_n (cpu_mreq_n),
  .cpu_rd_n   (cpu_rd_n),
  .rom_data   (rom_data),
  .cpu_rdata  (cpu_rdata),
  .vid_rdata  (vid_rdata)
);

// File: tb/sim_cpu_vram_bridge.sv
module sim_cpu_vram_bridge;
  logic        cpu_clk = 1'b0;
  logic        vid_clk = 1'b0;
  logic        cpu_rst = 1'b1;
  logic        vid_rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_mreq_n = 1'b1;
  logic        cpu_rd_n = 1'b1;
  logic        cpu_wr_n = 1'b1;
  logic [7:0]  rom_data = 8'h0;
  logic [7:0]  cpu_rdata, vid_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cpu_vram_bridge u0 (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .vid_clk(vid_clk), .vid_rst(vid_rst),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_mreq_n(cpu_mreq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .rom_data(rom_data),
    .cpu_rdata(cpu_rdata), .vid_rdata(vid_rdata)
  );

  always #4 cpu_clk = ~cpu_clk;
  initial begin
    #1;
    forever #2 vid_clk = ~vid_clk;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) + (i >> 8) + 8'h35);
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic mreq_n);
    @(negedge cpu_clk);
    cpu_addr = a; cpu_wdata = d; cpu_mreq_n = mreq_n; cpu_wr_n = 1'b0;
    @(negedge cpu_clk);
    cpu_mreq_n = 1'b1; cpu_wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] cd, output logic [7:0] vd);
    @(negedge cpu_clk);
    cpu_addr = a; cpu_mreq_n = 1'b0; cpu_rd_n = 1'b0;
    @(negedge cpu_clk);
    cd = cpu_rdata; vd = vid_rdata;
    cpu_mreq_n = 1'b1; cpu_rd_n = 1'b1;
  endtask

  task automatic t_reset();
    check(cpu_rdata == 8'hFF, "R9 cpu_rdata after reset", cpu_rdata, 8'hFF);
    check(vid_rdata == 8'h00, "R9 vid_rdata after reset", vid_rdata, 8'h00);
  endtask

  task automatic t_fill_and_readback();
    logic [7:0] c, v;
    for (int i = 0; i < 8192; i++) bus_write(16'(16'h2000 + i), pat(i), 1'b0);
    for (int i = 0; i < 8192; i++) begin
      bus_read(16'(16'h2000 + i), c, v);
      check(c == pat(i), "R1/R6 cpu readback", c, pat(i));
      check(v == pat(i), "R5 fast port readback", v, pat(i));
    end
    bus_read(16'h2000, c, v);
    check(c == pat(0), "R3 base maps to word 0", c, pat(0));
    bus_read(16'h3FFF, c, v);
    check(c == pat(8191), "R3 top maps to word 8191", c, pat(8191));
  endtask

  task automatic t_boundary_writes();
    logic [7:0] c, v;
    bus_write(16'h4000, ~pat(0), 1'b0);
    bus_write(16'h1FFF, ~pat(8191), 1'b0);
    bus_read(16'h2000, c, v);
    check(c == pat(0), "R2 write at 0x4000 ignored", c, pat(0));
    bus_read(16'h3FFF, c, v);
    check(c == pat(8191), "R2 write at 0x1FFF ignored", c, pat(8191));
  endtask

  task automatic t_no_mreq_write();
    logic [7:0] c, v;
    bus_write(16'h2100, ~pat(16'h100), 1'b1);
    bus_read(16'h2100, c, v);
    check(c == pat(16'h100), "R4 write without mreq ignored", c, pat(16'h100));
  endtask

  task automatic t_rom_reads();
    logic [7:0] c, v;
    rom_data = 8'h3C;
    bus_read(16'h0000, c, v);
    check(c == 8'h3C, "R7 rom at 0x0000", c, 8'h3C);
    rom_data = 8'hC3;
    bus_read(16'h1FFF, c, v);
    check(c == 8'hC3, "R7 rom at 0x1FFF", c, 8'hC3);
  endtask

  task automatic t_high_and_idle();
    logic [7:0] c, v;
    bus_read(16'h4000, c, v);
    check(c == 8'hFF, "R8 read at 0x4000", c, 8'hFF);
    bus_read(16'hFFFF, c, v);
    check(c == 8'hFF, "R8 read at 0xFFFF", c, 8'hFF);
    @(negedge cpu_clk);
    cpu_addr = 16'h2005; cpu_mreq_n = 1'b1; cpu_rd_n = 1'b0;
    @(negedge cpu_clk);
    check(cpu_rdata == 8'hFF, "R8 read strobe without mreq", cpu_rdata, 8'hFF);
    cpu_rd_n = 1'b1;
    @(negedge cpu_clk);
    check(cpu_rdata == 8'hFF, "R8 idle bus", cpu_rdata, 8'hFF);
  endtask

  task automatic t_hold();
    logic [7:0] c, v;
    bus_read(16'h2005, c, v);
    check(v == pat(5), "R5 fast port loads word 5", v, pat(5));
    rom_data = 8'h11;
    bus_read(16'h0010, c, v);
    check(v == pat(5), "R5 holds across rom read", v, pat(5));
    bus_read(16'h4001, c, v);
    check(v == pat(5), "R5 holds across high read", v, pat(5));
  endtask

  task automatic t_write_in_reset();
    logic [7:0] c, v;
    cpu_rst = 1'b1;
    bus_write(16'h2007, ~pat(7), 1'b0);
    cpu_rst = 1'b0;
    bus_read(16'h2007, c, v);
    check(c == pat(7), "R9 write blocked during cpu_rst", c, pat(7));
  endtask

  initial begin
    repeat (200000) @(posedge cpu_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge cpu_clk);
    cpu_rst = 1'b0; vid_rst = 1'b0;
    @(negedge cpu_clk);
    t_reset();
    t_fill_and_readback();
    t_boundary_writes();
    t_no_mreq_write();
    t_rom_reads();
    t_high_and_idle();
    t_hold();
    t_write_in_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule